// File: doc/BRIEF.md
# I2C Interrupt Event Status and Vector Unit

This unit sits beside an I2C controller's bit engine and turns its single-cycle event pulses into sticky status flags, a per-event interrupt enable mask, one interrupt line, and a vector register. There are seven events: arbitration lost, no acknowledge, register access ready, receive ready, transmit ready, stop condition seen, and addressed as a slave. A flag is set whenever its event pulses, whatever the mask says. The interrupt line reports whether any flag is both set and enabled.

Software reads the vector register to learn which enabled, pending event has the highest priority. That read also acknowledges the event it reports, so a handler can read the vector in a loop until it returns zero. Three of the flags can also be cleared by writing ones to the status register. The status word also carries two live bus conditions, receive-shift-full and bus-busy. These are never latched, never masked and never reported through the vector.

The interrupt line comes from a two-state machine. It moves from IRQ_QUIET to IRQ_RAISED on a clock edge where at least one enabled flag is pending. It moves from IRQ_RAISED back to IRQ_QUIET on an edge where none is. In each state it stays put otherwise.

Top module: `i2c_evt_irq_unit`

## Requirements
- R1: After reset every flag and mask bit is 0, the read data is 0 and the interrupt line is low.
- R2: An event pulse sets its status flag at the next clock edge, whether or not it is enabled. Flag bit positions are: arbitration lost 0, no acknowledge 1, access ready 2, receive ready 3, transmit ready 4, stop seen 5, addressed as slave 6.
- R3: A read of the status word (offset 0x08) returns the flags in bits 6..0, the live receive-shift-full input in bit 11 and the live bus-busy input in bit 12, with all other bits 0. The two live bits never affect the interrupt line or the vector.
- R4: Writing the status word clears flag 2, 3 or 5 wherever the written bit is 1. Written ones at flag positions 0, 1, 4 and 6, and written zeros anywhere, leave the flags unchanged.
- R5: The mask register (offset 0x04) is written from bits 6..0 of the write data, and bit i enables the flag at position i. It reads back with bits 15..7 as 0.
- R6: The interrupt line is high one cycle after an edge at which some flag and its mask bit were both 1, and low one cycle after an edge at which no such pair existed.
- R7: A read of the vector word (offset 0x28) returns, in bits 2..0, code i+1 for the lowest flag position i that is both set and enabled, or 0 if there is none. So the codes are arbitration lost 1, no acknowledge 2, access ready 3, receive ready 4, transmit ready 5, stop seen 6, addressed as slave 7.
- R8: A vector read clears exactly the flag it reports. Pending but masked flags, and a read that returns 0, clear nothing.
- R9: An event pulse in the same cycle as a clear of its own flag, by status write or by vector read, leaves the flag set.
- R10: Read data is registered: it appears in the cycle after the read strobe and holds until the next read. A read of any other offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 7 | Event pulses, bit i = flag position i |
| bus_busy_i | input | 1 | Live bus-busy condition |
| rx_full_i | input | 1 | Live receive-shift-full condition |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Registered read data |
| irq_o | output | 1 | Interrupt request |

## Verification
An event pulse, a status write or a vector read changes the flags at the same edge that samples it. Read data for any register is due one edge after the read strobe. The interrupt line follows the enabled-and-pending set one edge later than the flags, so it lags an event or a mask write by two edges. The bench drives inputs on falling edges and keeps a behavioural model that it updates on the same rising edges. On every falling edge it compares the read data and the interrupt line against that model, and the directed checks sample exactly those edges for the corner cases: set versus clear collisions, the priority order under partial masks, and reads of offsets that map to no register.

// File: rtl/i2c_ivec_pkg.sv
package i2c_ivec_pkg;

    // Vector codes reported for each event (flag position + 1)
    typedef enum logic [2:0] {
        VEC_NONE      = 3'd0,
        VEC_ARB_LOST  = 3'd1,
        VEC_NO_ACK    = 3'd2,
        VEC_ACC_RDY   = 3'd3,
        VEC_RX_RDY    = 3'd4,
        VEC_TX_RDY    = 3'd5,
        VEC_STOP_SEEN = 3'd6,
        VEC_SLV_ADDR  = 3'd7
    } ivec_code_e;

    // Interrupt line state machine
    typedef enum logic {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;

endpackage

// File: rtl/ivec_flag_bank.sv
module ivec_flag_bank #(
    parameter int unsigned N = 7,
    parameter logic [N-1:0] W1C_MASK = 7'b0101100
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] w1c_i,
    input  logic [N-1:0] ack_i,
    output logic [N-1:0] flag_o
);

    for (genvar i = 0; i < N; i++) begin : g_flag
        logic clr;
        if (W1C_MASK[i]) begin : g_w1c
            assign clr = w1c_i[i] | ack_i[i];
        end else begin : g_ack_only
            assign clr = ack_i[i];
        end

        // a new event always wins over a clear in the same cycle
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                flag_o[i] <= 1'b0;
            else if (set_i[i])
                flag_o[i] <= 1'b1;
            else if (clr)
                flag_o[i] <= 1'b0;
        end
    end

endmodule

// File: rtl/ivec_prio_enc.sv
module ivec_prio_enc #(
    parameter int unsigned N = 7,
    localparam int unsigned CODE_W = $clog2(N + 1)
) (
    input  logic [N-1:0]      pend_i,
    output logic [CODE_W-1:0] code_o,
    output logic [N-1:0]      sel_o
);

    // walk from the top down so the lowest pending position is kept
    always_comb begin
        code_o = '0;
        sel_o  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend_i[i]) begin
                code_o   = CODE_W'(i + 1);
                sel_o    = '0;
                sel_o[i] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/ivec_irq_fsm.sv
module ivec_irq_fsm
    import i2c_ivec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_pend_i,
    output logic irq_o
);

    irq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:  if (any_pend_i)  state_d = IRQ_RAISED;
            IRQ_RAISED: if (!any_pend_i) state_d = IRQ_QUIET;
            default:    state_d = IRQ_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= IRQ_QUIET;
        else
            state_q <= state_d;
    end

    always_comb begin
        irq_o = (state_q == IRQ_RAISED);
    end

endmodule

// File: rtl/i2c_evt_irq_unit.sv
module i2c_evt_irq_unit #(
    parameter int unsigned NUM_EVT    = 7,
    parameter int unsigned DATA_W     = 16,
    parameter int unsigned ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] MASK_OFS = 8'h04,
    parameter logic [ADDR_W-1:0] STAT_OFS = 8'h08,
    parameter logic [ADDR_W-1:0] VEC_OFS  = 8'h28,
    parameter int unsigned RXFULL_BIT = 11,
    parameter int unsigned BUSY_BIT   = 12,
    parameter logic [NUM_EVT-1:0] W1C_MASK = 7'b0101100
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic               bus_busy_i,
    input  logic               rx_full_i,
    input  logic [ADDR_W-1:0]  reg_addr_i,
    input  logic               reg_wr_i,
    input  logic               reg_rd_i,
    input  logic [DATA_W-1:0]  reg_wdata_i,
    output logic [DATA_W-1:0]  reg_rdata_o,
    output logic               irq_o
);

    localparam int unsigned CODE_W = $clog2(NUM_EVT + 1);

    logic [NUM_EVT-1:0] flag_q;
    logic [NUM_EVT-1:0] mask_q;
    logic [NUM_EVT-1:0] pend;
    logic [NUM_EVT-1:0] top_sel;
    logic [NUM_EVT-1:0] w1c;
    logic [NUM_EVT-1:0] ack;
    logic [CODE_W-1:0]  top_code;
    logic               hit_mask, hit_stat, hit_vec;
    logic [DATA_W-1:0]  rd_word;
    logic               unused_wdata;

    assign unused_wdata = ^reg_wdata_i[DATA_W-1:NUM_EVT];

    assign hit_mask = (reg_addr_i == MASK_OFS);
    assign hit_stat = (reg_addr_i == STAT_OFS);
    assign hit_vec  = (reg_addr_i == VEC_OFS);

    assign pend = flag_q & mask_q;
    assign w1c  = (reg_wr_i && hit_stat) ? reg_wdata_i[NUM_EVT-1:0] : '0;
    assign ack  = (reg_rd_i && hit_vec) ? top_sel : '0;

    ivec_flag_bank #(.N(NUM_EVT), .W1C_MASK(W1C_MASK)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (evt_i),
        .w1c_i  (w1c),
        .ack_i  (ack),
        .flag_o (flag_q)
    );

    ivec_prio_enc #(.N(NUM_EVT)) u_prio (
        .pend_i (pend),
        .code_o (top_code),
        .sel_o  (top_sel)
    );

    ivec_irq_fsm u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .any_pend_i (|pend),
        .irq_o      (irq_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mask_q <= '0;
        else if (reg_wr_i && hit_mask)
            mask_q <= reg_wdata_i[NUM_EVT-1:0];
    end

    always_comb begin
        rd_word = '0;
        if (hit_mask) begin
            rd_word[NUM_EVT-1:0] = mask_q;
        end else if (hit_stat) begin
            rd_word[NUM_EVT-1:0] = flag_q;
            rd_word[RXFULL_BIT]  = rx_full_i;
            rd_word[BUSY_BIT]    = bus_busy_i;
        end else if (hit_vec) begin
            rd_word[CODE_W-1:0]  = top_code;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            reg_rdata_o <= '0;
        else if (reg_rd_i)
            reg_rdata_o <= rd_word;
    end

endmodule

// File: rtl/ivec_unit_chk.sv
module ivec_unit_chk #(
    parameter int unsigned NUM_EVT = 7,
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] MASK_OFS = 8'h04,
    parameter logic [ADDR_W-1:0] STAT_OFS = 8'h08,
    parameter logic [ADDR_W-1:0] VEC_OFS  = 8'h28,
    localparam int unsigned CODE_W = $clog2(NUM_EVT + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_EVT-1:0] evt_i,
    input logic [ADDR_W-1:0]  reg_addr_i,
    input logic               reg_wr_i,
    input logic               reg_rd_i,
    input logic [DATA_W-1:0]  reg_rdata_o,
    input logic               irq_o,
    input logic [NUM_EVT-1:0] flag_q,
    input logic [NUM_EVT-1:0] mask_q
);

    logic [CODE_W-1:0] got_code;
    logic              got_cleared;
    logic              other_addr;

    assign got_code    = reg_rdata_o[CODE_W-1:0];
    assign got_cleared = (got_code == '0) || !flag_q[got_code - CODE_W'(1)];
    assign other_addr  = (reg_addr_i != MASK_OFS) && (reg_addr_i != STAT_OFS) &&
                         (reg_addr_i != VEC_OFS);

    // R6
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(flag_q & mask_q)) |=> irq_o);

    // R6
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(flag_q & mask_q)) |=> !irq_o);

    // R9
    evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> ((flag_q & $past(evt_i)) == $past(evt_i)));

    // R7
    vec_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_i && reg_addr_i == VEC_OFS) |=>
            ((reg_rdata_o == '0) == ($past(flag_q & mask_q) == '0)));

    // R8
    vec_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_i && reg_addr_i == VEC_OFS && evt_i == '0) |=> got_cleared);

    // R4
    no_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_addr_i == STAT_OFS && !evt_i[0]) |=> $stable(flag_q[0]));

    // R10
    unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_i && other_addr) |=> (reg_rdata_o == '0));

endmodule

bind i2c_evt_irq_unit ivec_unit_chk #(
    .NUM_EVT(NUM_EVT), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .MASK_OFS(MASK_OFS), .STAT_OFS(STAT_OFS), .VEC_OFS(VEC_OFS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_i       (evt_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wr_i    (reg_wr_i),
    .reg_rd_i    (reg_rd_i),
    .reg_rdata_o (reg_rdata_o),
    .irq_o       (irq_o),
    .flag_q      (flag_q),
    .mask_q      (mask_q)
);

// File: tb/sim_i2c_evt_irq_unit.sv
`timescale 1ns/1ps
module sim_i2c_evt_irq_unit;

    localparam logic [7:0] A_MASK = 8'h04;
    localparam logic [7:0] A_STAT = 8'h08;
    localparam logic [7:0] A_VEC  = 8'h28;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  evt = '0;
    logic        busy = 1'b0;
    logic        rxf = 1'b0;
    logic [7:0]  addr = '0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    i2c_evt_irq_unit u0 (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .bus_busy_i(busy), .rx_full_i(rxf),
        .reg_addr_i(addr), .reg_wr_i(wr), .reg_rd_i(rd), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .irq_o(irq)
    );

    // behavioural reference model
    logic [6:0]  m_flag, m_mask, m_pend, m_nflag;
    logic [15:0] m_rdata;
    logic        m_irq;
    int          m_code;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_flag = '0; m_mask = '0; m_rdata = '0; m_irq = 1'b0;
        end else begin
            m_pend = m_flag & m_mask;
            m_code = 0;
            for (int i = 6; i >= 0; i--) if (m_pend[i]) m_code = i + 1;
            m_nflag = m_flag;
            if (rd) begin
                if (addr == A_MASK)      m_rdata = {9'd0, m_mask};
                else if (addr == A_STAT) m_rdata = {3'd0, busy, rxf, 4'd0, m_flag};
                else if (addr == A_VEC)  m_rdata = 16'(m_code);
                else                     m_rdata = 16'd0;
                if (addr == A_VEC && m_code != 0) m_nflag[m_code-1] = 1'b0;
            end
            if (wr && addr == A_STAT) m_nflag = m_nflag & ~(wdata[6:0] & 7'b0101100);
            if (wr && addr == A_MASK) m_mask = wdata[6:0];
            m_irq  = (m_pend != 0);
            m_flag = m_nflag | evt;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (rdata !== m_rdata) begin
                fails++;
                $display("FAIL R10 cycle compare rdata: actual %h expected %h", rdata, m_rdata);
            end
            checks++;
            if (irq !== m_irq) begin
                fails++;
                $display("FAIL R6 cycle compare irq: actual %0d expected %0d", irq, m_irq);
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [6:0] e, input logic r, input logic w,
                        input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        evt = e; rd = r; wr = w; addr = a; wdata = d;
        @(negedge clk);
        evt = '0; rd = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [15:0] d);
        step(7'd0, 1'b1, 1'b0, a, 16'd0);
        d = rdata;
    endtask

    task automatic drain();
        logic [15:0] d;
        step(7'd0, 1'b0, 1'b1, A_MASK, 16'h007F);
        for (int k = 0; k < 8; k++) rd_reg(A_VEC, d);
        step(7'd0, 1'b0, 1'b1, A_MASK, 16'h0000);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        repeat (3) @(negedge clk);
        chk("R1 irq in reset", irq, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 irq after reset", irq, 0);
        chk("R1 rdata after reset", rdata, 0);
        rd_reg(A_MASK, d); chk("R1 mask reset", d, 16'h0000);
        rd_reg(A_STAT, d); chk("R1 status reset", d, 16'h0000);
        rd_reg(A_VEC, d);  chk("R1 vector reset", d, 16'h0000);

        // masked event: flag set, no interrupt, vector empty
        step(7'h01, 1'b0, 1'b0, 8'h00, 16'd0);
        @(negedge clk);
        chk("R6 masked event no irq", irq, 0);
        rd_reg(A_STAT, d); chk("R2 flag set while masked", d, 16'h0001);
        rd_reg(A_VEC, d);  chk("R7 masked vector empty", d, 16'h0000);
        rd_reg(A_STAT, d); chk("R8 masked flag kept", d, 16'h0001);

        // live bits
        busy = 1'b1; rxf = 1'b1;
        rd_reg(A_STAT, d); chk("R3 live bits", d, 16'h1801);
        chk("R3 live bits no irq", irq, 0);
        busy = 1'b0; rxf = 1'b0;

        // mask register
        step(7'd0, 1'b0, 1'b1, A_MASK, 16'hFFFF);
        rd_reg(A_MASK, d); chk("R5 mask upper bits zero", d, 16'h007F);
        chk("R6 irq after mask enable", irq, 1);

        // priority loop
        step(7'h7F, 1'b0, 1'b0, 8'h00, 16'd0);
        for (int c = 1; c <= 7; c++) begin
            rd_reg(A_VEC, d); chk("R7 vector order", d, c);
        end
        rd_reg(A_VEC, d); chk("R8 all acknowledged", d, 0);
        @(negedge clk);
        chk("R6 irq drops", irq, 0);

        // write-one-to-clear
        step(7'h7F, 1'b0, 1'b0, 8'h00, 16'd0);
        step(7'd0, 1'b0, 1'b1, A_STAT, 16'h007F);
        rd_reg(A_STAT, d); chk("R4 selective clear", d, 16'h0053);
        step(7'd0, 1'b0, 1'b1, A_STAT, 16'h0000);
        rd_reg(A_STAT, d); chk("R4 zero write no effect", d, 16'h0053);
        drain();
        rd_reg(A_STAT, d); chk("R8 drained", d, 16'h0000);

        // set versus clear collisions
        step(7'h04, 1'b0, 1'b1, A_STAT, 16'h0004);
        rd_reg(A_STAT, d); chk("R9 event beats status clear", d, 16'h0004);
        step(7'd0, 1'b0, 1'b1, A_MASK, 16'h007F);
        step(7'h04, 1'b1, 1'b0, A_VEC, 16'd0);
        chk("R9 vector code on collision", rdata, 3);
        rd_reg(A_STAT, d); chk("R9 event beats vector ack", d, 16'h0004);
        step(7'd0, 1'b0, 1'b1, A_STAT, 16'h0004);
        rd_reg(A_STAT, d); chk("R4 access ready cleared", d, 16'h0000);

        // partial mask priority
        step(7'd0, 1'b0, 1'b1, A_MASK, 16'h0028);
        step(7'h2A, 1'b0, 1'b0, 8'h00, 16'd0);
        rd_reg(A_VEC, d); chk("R7 partial mask first", d, 4);
        rd_reg(A_VEC, d); chk("R7 partial mask second", d, 6);
        rd_reg(A_VEC, d); chk("R7 partial mask empty", d, 0);
        rd_reg(A_STAT, d); chk("R8 masked flag untouched", d, 16'h0002);

        // unmapped offsets and hold
        rd_reg(8'h10, d); chk("R10 unmapped read", d, 0);
        step(7'd0, 1'b0, 1'b1, A_MASK, 16'h0011);
        rd_reg(A_MASK, d);
        repeat (3) @(negedge clk);
        chk("R10 read data holds", rdata, 16'h0011);
        rd_reg(8'h0C, d); chk("R10 unmapped read 2", d, 0);

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule